// File: doc/BRIEF.md
# Processor Control and Status Register Access Unit

This unit serves the control-and-status register (CSR) instructions of a 32-bit RISC-V style core. Each cycle the core may present one access: a 12-bit register address, a 3-bit operation code taken from the instruction's function field, the register operand, the raw 5-bit rs1 field and a flag telling whether the destination register is x0. In the same cycle the unit returns the register's value before the access and a flag marking the access as illegal. Any update lands on the next clock edge.

Whether an access is legal is decided from the address alone, together with the operation. Two address bits give the least privileged mode that may touch the register. Two more mark the register as read-only. Whether the instruction intends to read or write at all follows from the x0 cases. The unit keeps two 64-bit counters, for clock cycles and for retired instructions. Both can be read as 32-bit halves at user level and written through machine-level aliases. It also passes through an externally supplied 64-bit time value and answers the constant machine identification registers. The trap logic of the core loads the current privilege mode through a separate strobe.

Top module: `csr_unit`

## Requirements
- R1: The operation code selects the update: 1 replaces the register with the operand, 2 yields old OR operand, 3 yields old AND NOT operand. Codes 5, 6 and 7 do the same with the zero-extended 5-bit rs1 field as operand. Codes 0 and 4 make the access illegal.
- R2: The response appears combinationally in the cycle of the request and carries the value before the update. The update becomes visible from the next cycle on.
- R3: For codes 1 and 5 with the x0-destination flag set, no read takes place: the response data is zero, and the write still happens.
- R4: For codes 2, 3, 6 and 7 with a zero rs1 field, the access is a pure read with no write. Such an access is legal on read-only registers.
- R5: Privilege encodings are user 0, supervisor 1 and machine 3. After reset the mode is machine, and a load strobe replaces it. An access is illegal when address bits [9:8] exceed the current mode.
- R6: An address whose bits [11:10] are both 1 is read-only, and any access that intends to write it is illegal.
- R7: An address that decodes to no register is illegal. An illegal access returns zero data and changes no register. The illegal flag is low whenever no request is presented.
- R8: Reads at 0xC00/0xC80 return the cycle counter's low and high halves, 0xC02/0xC82 those of the retired-instruction counter, and 0xC01/0xC81 those of the time input. The machine-level aliases 0xB00/0xB80 and 0xB02/0xB82 read the same counter halves and are writable.
- R9: The cycle counter advances by one every clock. The retired-instruction counter advances by one in each cycle in which the retire strobe is high. Carries propagate from the low half into the high half.
- R10: A write to one half of a counter takes precedence over that counter's increment in the same cycle and leaves the other half unchanged.
- R11: Address 0x301 reads the constant 0x40141100, that is bits 30, 20, 18, 12 and 8. Writes to it are legal and ignored.
- R12: Addresses 0xF11, 0xF12 and 0xF13 read zero, and 0xF14 reads the HART_ID parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| priv_load | input | 1 | Load strobe for the current privilege mode |
| priv_next | input | 2 | New privilege mode (0 user, 1 supervisor, 3 machine) |
| retire | input | 1 | One instruction retired this cycle |
| time_in | input | 64 | Platform time value |
| req_valid | input | 1 | An access is presented this cycle |
| req_addr | input | 12 | Register address |
| req_op | input | 3 | Operation code |
| req_rd_zero | input | 1 | Destination register is x0 |
| req_rs1 | input | 5 | Raw rs1 field, also the immediate operand |
| req_src | input | 32 | Register operand for codes 1 to 3 |
| rsp_rdata | output | 32 | Register value before the access |
| rsp_illegal | output | 1 | The access is illegal |

## Verification
Two updates can collide in the same cycle. The first is a software write to a counter half, through a machine-level alias. The second is that counter's own increment, which is the free-running clock count for the cycle counter and a retire strobe for the instruction counter. The bench writes the cycle counter while it runs and writes the instruction counter with retire held high. It then reads the counter in the very next cycle and expects exactly the written value in the written half and the old value in the other half. A carry is also forced from a low half of all ones into a preset high half, and the bench checks that the high half reads one more.

// File: rtl/csr_pkg.sv
package csr_pkg;

  localparam int XLEN  = 32;
  localparam int CNT_W = 64;
  localparam int IMM_W = 5;

  typedef enum logic [1:0] {
    PRV_U   = 2'd0,
    PRV_S   = 2'd1,
    PRV_RSV = 2'd2,
    PRV_M   = 2'd3
  } priv_e;

  // low two bits of the operation code
  typedef enum logic [1:0] {
    OPK_BAD   = 2'd0,
    OPK_WRITE = 2'd1,
    OPK_SET   = 2'd2,
    OPK_CLEAR = 2'd3
  } opkind_e;

  typedef enum logic [3:0] {
    SRC_NONE,
    SRC_CYC_LO,
    SRC_CYC_HI,
    SRC_TIME_LO,
    SRC_TIME_HI,
    SRC_RET_LO,
    SRC_RET_HI,
    SRC_ISA,
    SRC_ZERO,
    SRC_HART
  } src_e;

  localparam logic [11:0] A_CYC_LO   = 12'hC00;
  localparam logic [11:0] A_TIME_LO  = 12'hC01;
  localparam logic [11:0] A_RET_LO   = 12'hC02;
  localparam logic [11:0] A_CYC_HI   = 12'hC80;
  localparam logic [11:0] A_TIME_HI  = 12'hC81;
  localparam logic [11:0] A_RET_HI   = 12'hC82;
  localparam logic [11:0] A_MCYC_LO  = 12'hB00;
  localparam logic [11:0] A_MRET_LO  = 12'hB02;
  localparam logic [11:0] A_MCYC_HI  = 12'hB80;
  localparam logic [11:0] A_MRET_HI  = 12'hB82;
  localparam logic [11:0] A_ISA      = 12'h301;
  localparam logic [11:0] A_VENDOR   = 12'hF11;
  localparam logic [11:0] A_ARCH     = 12'hF12;
  localparam logic [11:0] A_IMPL     = 12'hF13;
  localparam logic [11:0] A_HART     = 12'hF14;

  // ISA descriptor: 32-bit base, integer base, multiply, supervisor, user
  function automatic logic [XLEN-1:0] isa_word();
    logic [XLEN-1:0] w;
    w = '0;
    w[30] = 1'b1;
    w[8]  = 1'b1;
    w[12] = 1'b1;
    w[18] = 1'b1;
    w[20] = 1'b1;
    return w;
  endfunction

  // new register value for an access of the given kind
  function automatic logic [XLEN-1:0] apply_op(opkind_e kind,
                                               logic [XLEN-1:0] old_v,
                                               logic [XLEN-1:0] opd);
    logic [XLEN-1:0] r;
    unique case (kind)
      OPK_WRITE: r = opd;
      OPK_SET:   r = old_v | opd;
      OPK_CLEAR: r = old_v & ~opd;
      default:   r = old_v;
    endcase
    return r;
  endfunction

  // select one half of a double-width value
  function automatic logic [XLEN-1:0] half_of(logic [CNT_W-1:0] v, logic upper);
    return upper ? v[CNT_W-1:XLEN] : v[XLEN-1:0];
  endfunction

endpackage

// File: rtl/csr_access_check.sv
module csr_access_check
  import csr_pkg::*;
#(
  parameter int IW = IMM_W
) (
  input  logic          valid,
  input  logic [11:0]   addr,
  input  logic [2:0]    op,
  input  logic          rd_zero,
  input  logic [IW-1:0] rs1_field,
  input  priv_e         cur_priv,
  output src_e          src,
  output logic          cnt_alias,
  output opkind_e       kind,
  output logic          use_imm,
  output logic          legal,
  output logic          do_read,
  output logic          do_write,
  output logic          illegal
);

  logic hit;
  logic op_ok;
  logic wr_intent;
  logic rd_intent;
  logic priv_ok;
  logic read_only;

  always_comb begin
    hit = 1'b1;
    unique case (addr)
      A_CYC_LO, A_MCYC_LO: src = SRC_CYC_LO;
      A_CYC_HI, A_MCYC_HI: src = SRC_CYC_HI;
      A_RET_LO, A_MRET_LO: src = SRC_RET_LO;
      A_RET_HI, A_MRET_HI: src = SRC_RET_HI;
      A_TIME_LO:           src = SRC_TIME_LO;
      A_TIME_HI:           src = SRC_TIME_HI;
      A_ISA:               src = SRC_ISA;
      A_VENDOR, A_ARCH, A_IMPL: src = SRC_ZERO;
      A_HART:              src = SRC_HART;
      default: begin
        src = SRC_NONE;
        hit = 1'b0;
      end
    endcase
  end

  assign cnt_alias = (addr[11:8] == 4'hB);
  assign kind      = opkind_e'(op[1:0]);
  assign use_imm   = op[2];
  assign op_ok     = (kind != OPK_BAD);

  // a write is intended unless a set/clear has a zero rs1 field
  assign wr_intent = (kind == OPK_WRITE) || (rs1_field != '0);
  // a plain write into x0 does not read
  assign rd_intent = !((kind == OPK_WRITE) && rd_zero);

  assign priv_ok   = (cur_priv >= priv_e'(addr[9:8]));
  assign read_only = &addr[11:10];

  assign legal    = valid && hit && op_ok && priv_ok && !(read_only && wr_intent);
  assign do_read  = legal && rd_intent;
  assign do_write = legal && wr_intent;
  assign illegal  = valid && !legal;

endmodule

// File: rtl/csr_counter64.sv
module csr_counter64 #(
  parameter int W    = 64,
  parameter int HALF = W / 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inc,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [HALF-1:0] wdata,
  output logic [W-1:0]    count
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (wr_lo) begin
      count <= {count[W-1:HALF], wdata};
    end else if (wr_hi) begin
      count <= {wdata, count[HALF-1:0]};
    end else if (inc) begin
      count <= count + W'(1);
    end
  end

endmodule

// File: rtl/csr_read_mux.sv
module csr_read_mux
  import csr_pkg::*;
#(
  parameter logic [XLEN-1:0] HART_ID = '0
) (
  input  src_e             src,
  input  logic [CNT_W-1:0] cyc,
  input  logic [CNT_W-1:0] ret,
  input  logic [CNT_W-1:0] tim,
  output logic [XLEN-1:0]  value
);

  always_comb begin
    unique case (src)
      SRC_CYC_LO:  value = half_of(cyc, 1'b0);
      SRC_CYC_HI:  value = half_of(cyc, 1'b1);
      SRC_RET_LO:  value = half_of(ret, 1'b0);
      SRC_RET_HI:  value = half_of(ret, 1'b1);
      SRC_TIME_LO: value = half_of(tim, 1'b0);
      SRC_TIME_HI: value = half_of(tim, 1'b1);
      SRC_ISA:     value = isa_word();
      SRC_HART:    value = HART_ID;
      default:     value = '0;
    endcase
  end

endmodule

// File: rtl/csr_unit.sv
module csr_unit
  import csr_pkg::*;
#(
  parameter logic [31:0] HART_ID = 32'd0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        priv_load,
  input  logic [1:0]  priv_next,
  input  logic        retire,
  input  logic [63:0] time_in,
  input  logic        req_valid,
  input  logic [11:0] req_addr,
  input  logic [2:0]  req_op,
  input  logic        req_rd_zero,
  input  logic [4:0]  req_rs1,
  input  logic [31:0] req_src,
  output logic [31:0] rsp_rdata,
  output logic        rsp_illegal
);

  localparam int NCNT    = 2;
  localparam int CNT_CYC = 0;
  localparam int CNT_RET = 1;
  localparam int HALF    = CNT_W / 2;

  priv_e            priv_q;
  src_e             acc_src;
  logic             acc_alias;
  opkind_e          acc_kind;
  logic             acc_imm;
  logic             acc_legal;
  logic             acc_read;
  logic             acc_write;
  logic             acc_illegal;
  logic [XLEN-1:0]  raw_value;
  logic [XLEN-1:0]  operand;
  logic [XLEN-1:0]  wr_data;
  logic             cnt_wr;

  logic [NCNT-1:0]  cnt_inc;
  logic [NCNT-1:0]  cnt_wr_lo;
  logic [NCNT-1:0]  cnt_wr_hi;
  logic [CNT_W-1:0] cnt_val [NCNT];

  // current privilege mode, loaded by the trap logic
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      priv_q <= PRV_M;
    end else if (priv_load) begin
      priv_q <= priv_e'(priv_next);
    end
  end

  csr_access_check #(.IW(IMM_W)) u_check (
    .valid     (req_valid),
    .addr      (req_addr),
    .op        (req_op),
    .rd_zero   (req_rd_zero),
    .rs1_field (req_rs1),
    .cur_priv  (priv_q),
    .src       (acc_src),
    .cnt_alias (acc_alias),
    .kind      (acc_kind),
    .use_imm   (acc_imm),
    .legal     (acc_legal),
    .do_read   (acc_read),
    .do_write  (acc_write),
    .illegal   (acc_illegal)
  );

  csr_read_mux #(.HART_ID(HART_ID)) u_mux (
    .src   (acc_src),
    .cyc   (cnt_val[CNT_CYC]),
    .ret   (cnt_val[CNT_RET]),
    .tim   (time_in),
    .value (raw_value)
  );

  assign operand = acc_imm ? XLEN'(req_rs1) : req_src;
  assign wr_data = apply_op(acc_kind, raw_value, operand);
  assign cnt_wr  = acc_write && acc_alias;

  assign cnt_inc[CNT_CYC]   = 1'b1;
  assign cnt_inc[CNT_RET]   = retire;
  assign cnt_wr_lo[CNT_CYC] = cnt_wr && (acc_src == SRC_CYC_LO);
  assign cnt_wr_hi[CNT_CYC] = cnt_wr && (acc_src == SRC_CYC_HI);
  assign cnt_wr_lo[CNT_RET] = cnt_wr && (acc_src == SRC_RET_LO);
  assign cnt_wr_hi[CNT_RET] = cnt_wr && (acc_src == SRC_RET_HI);

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    csr_counter64 #(.W(CNT_W), .HALF(HALF)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (cnt_inc[g]),
      .wr_lo (cnt_wr_lo[g]),
      .wr_hi (cnt_wr_hi[g]),
      .wdata (wr_data),
      .count (cnt_val[g])
    );
  end

  assign rsp_rdata   = acc_read ? raw_value : '0;
  assign rsp_illegal = acc_illegal;

endmodule

// File: rtl/csr_unit_chk.sv
module csr_unit_chk #(
  parameter int CW = 64,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [11:0]   req_addr,
  input logic [2:0]    req_op,
  input logic          req_rd_zero,
  input logic [DW-1:0] rsp_rdata,
  input logic          rsp_illegal,
  input logic [1:0]    priv_q,
  input logic          retire,
  input logic [CW-1:0] cyc_q,
  input logic [CW-1:0] ret_q,
  input logic [1:0]    wr_lo,
  input logic [1:0]    wr_hi,
  input logic [DW-1:0] wr_data
);

  logic cyc_wr;
  logic ret_wr;
  assign cyc_wr = wr_lo[0] || wr_hi[0];
  assign ret_wr = wr_lo[1] || wr_hi[1];

  assert_illegal_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_illegal |-> (rsp_rdata == '0));

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !rsp_illegal);

  assert_illegal_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_illegal |-> (wr_lo == 2'b00 && wr_hi == 2'b00));

  assert_priv_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_addr[9:8] > priv_q)) |-> rsp_illegal);

  assert_ro_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (&req_addr[11:10]) && (req_op[1:0] == 2'b01)) |-> rsp_illegal);

  assert_no_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_rd_zero && (req_op[1:0] == 2'b01)) |-> (rsp_rdata == '0));

  assert_cycle_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_wr |=> (cyc_q == $past(cyc_q) + CW'(1)));

  assert_retire_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_wr && retire) |=> (ret_q == $past(ret_q) + CW'(1)));

  assert_retire_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_wr && !retire) |=> $stable(ret_q));

  assert_cycle_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo[0] |=> (cyc_q[DW-1:0] == $past(wr_data)) && (cyc_q[CW-1:DW] == $past(cyc_q[CW-1:DW])));

  assert_retire_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi[1] |=> (ret_q[CW-1:DW] == $past(wr_data)) && (ret_q[DW-1:0] == $past(ret_q[DW-1:0])));

  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_lo, wr_hi}));

endmodule

bind csr_unit csr_unit_chk #(.CW(64), .DW(32)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_addr    (req_addr),
  .req_op      (req_op),
  .req_rd_zero (req_rd_zero),
  .rsp_rdata   (rsp_rdata),
  .rsp_illegal (rsp_illegal),
  .priv_q      (priv_q),
  .retire      (retire),
  .cyc_q       (cnt_val[0]),
  .ret_q       (cnt_val[1]),
  .wr_lo       (cnt_wr_lo),
  .wr_hi       (cnt_wr_hi),
  .wr_data     (wr_data)
);

// File: tb/csr_unit_tb.sv
`timescale 1ns/1ps
module csr_unit_tb;

  localparam logic [31:0] HART = 32'h0000_002A;
  localparam logic [31:0] ISA  = 32'h4014_1100;
  localparam logic [63:0] TIMV = 64'h1234_5678_9ABC_DEF0;

  typedef struct packed {
    logic [11:0] addr;
    logic [2:0]  op;
    logic        rdz;
    logic [4:0]  rs1;
    logic [31:0] src;
    logic        ill;
    logic [31:0] rdata;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{12'hF11, 3'd2, 1'b0, 5'd0, 32'h0,        1'b0, 32'h0},        // R12
    '{12'hF14, 3'd2, 1'b0, 5'd0, 32'h0,        1'b0, HART},         // R12
    '{12'h301, 3'd2, 1'b0, 5'd0, 32'h0,        1'b0, ISA},          // R11
    '{12'h301, 3'd1, 1'b0, 5'd1, 32'hFFFF_FFFF, 1'b0, ISA},         // R11
    '{12'h301, 3'd2, 1'b0, 5'd0, 32'h0,        1'b0, ISA},          // R11
    '{12'hB02, 3'd1, 1'b1, 5'd2, 32'h10,       1'b0, 32'h0},        // R3
    '{12'hC02, 3'd2, 1'b0, 5'd0, 32'h0,        1'b0, 32'h10},       // R3
    '{12'hB02, 3'd2, 1'b0, 5'd5, 32'h0F,       1'b0, 32'h10},       // R1
    '{12'hC02, 3'd6, 1'b0, 5'd0, 32'h0,        1'b0, 32'h1F},       // R1
    '{12'hB02, 3'd7, 1'b0, 5'd3, 32'hFFFF_FFFF, 1'b0, 32'h1F},      // R1
    '{12'hC02, 3'd2, 1'b0, 5'd0, 32'h0,        1'b0, 32'h1C},       // R1
    '{12'hB82, 3'd5, 1'b0, 5'd9, 32'hFFFF_FFFF, 1'b0, 32'h0},       // R2
    '{12'hC82, 3'd2, 1'b0, 5'd0, 32'h0,        1'b0, 32'h9},        // R8
    '{12'hC02, 3'd1, 1'b0, 5'd0, 32'h0,        1'b1, 32'h0},        // R6
    '{12'hC02, 3'd3, 1'b0, 5'd1, 32'h0,        1'b1, 32'h0},        // R6
    '{12'hC02, 3'd3, 1'b0, 5'd0, 32'hFFFF_FFFF, 1'b0, 32'h1C},      // R4
    '{12'hC02, 3'd0, 1'b0, 5'd0, 32'h0,        1'b1, 32'h0},        // R1
    '{12'h7C0, 3'd2, 1'b0, 5'd0, 32'h0,        1'b1, 32'h0},        // R7
    '{12'hC82, 3'd2, 1'b0, 5'd0, 32'h0,        1'b0, 32'h9},        // R7
    '{12'hC01, 3'd2, 1'b0, 5'd0, 32'h0,        1'b0, 32'h9ABC_DEF0}, // R8
    '{12'hC81, 3'd6, 1'b0, 5'd0, 32'h0,        1'b0, 32'h1234_5678}, // R8
    '{12'hF12, 3'd1, 1'b1, 5'd0, 32'h1,        1'b1, 32'h0},        // R6
    '{12'hB02, 3'd4, 1'b0, 5'd1, 32'h0,        1'b1, 32'h0},        // R1
    '{12'hC02, 3'd2, 1'b0, 5'd0, 32'h0,        1'b0, 32'h1C}        // R7
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        priv_load = 1'b0;
  logic [1:0]  priv_next = 2'd0;
  logic        retire = 1'b0;
  logic [63:0] time_in = TIMV;
  logic        req_valid = 1'b0;
  logic [11:0] req_addr = '0;
  logic [2:0]  req_op = '0;
  logic        req_rd_zero = 1'b0;
  logic [4:0]  req_rs1 = '0;
  logic [31:0] req_src = '0;
  logic [31:0] rsp_rdata;
  logic        rsp_illegal;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  csr_unit #(.HART_ID(HART)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .priv_load   (priv_load),
    .priv_next   (priv_next),
    .retire      (retire),
    .time_in     (time_in),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_op      (req_op),
    .req_rd_zero (req_rd_zero),
    .req_rs1     (req_rs1),
    .req_src     (req_src),
    .rsp_rdata   (rsp_rdata),
    .rsp_illegal (rsp_illegal)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one request at the falling edge, settle before the rising edge
  task automatic access(input logic [11:0] a, input logic [2:0] op, input logic rdz,
                        input logic [4:0] rs1, input logic [31:0] src, input logic ret);
    @(negedge clk);
    priv_load   = 1'b0;
    retire      = ret;
    req_valid   = 1'b1;
    req_addr    = a;
    req_op      = op;
    req_rd_zero = rdz;
    req_rs1     = rs1;
    req_src     = src;
    #1;
  endtask

  task automatic idle(input logic ret);
    @(negedge clk);
    priv_load = 1'b0;
    retire    = ret;
    req_valid = 1'b0;
    #1;
  endtask

  task automatic set_priv(input logic [1:0] p);
    @(negedge clk);
    req_valid = 1'b0;
    retire    = 1'b0;
    priv_load = 1'b1;
    priv_next = p;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v1;
    logic [31:0] v2;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R7 idle flag after reset", {31'b0, rsp_illegal}, 32'h0);
    chk("R7 idle data after reset", rsp_rdata, 32'h0);
    access(12'hC02, 3'd2, 1'b0, 5'd0, 32'h0, 1'b0);
    chk("R9 retired count after reset", rsp_rdata, 32'h0);
    access(12'hB82, 3'd2, 1'b0, 5'd0, 32'h0, 1'b0);
    chk("R5 machine mode after reset", {31'b0, rsp_illegal}, 32'h0);

    // vector table, machine mode, retire held low
    for (int i = 0; i < NV; i++) begin
      access(VEC[i].addr, VEC[i].op, VEC[i].rdz, VEC[i].rs1, VEC[i].src, 1'b0);
      chk($sformatf("R1..table %0d illegal flag", i), {31'b0, rsp_illegal}, {31'b0, VEC[i].ill});
      chk($sformatf("R2 table %0d data", i), rsp_rdata, VEC[i].rdata);
    end

    // R9: cycle counter advances once per clock
    access(12'hC00, 3'd2, 1'b0, 5'd0, 32'h0, 1'b0);
    v1 = rsp_rdata;
    repeat (4) idle(1'b0);
    access(12'hC00, 3'd2, 1'b0, 5'd0, 32'h0, 1'b0);
    chk("R9 cycle distance", rsp_rdata - v1, 32'd5);

    // R10: write wins over the increment in the same cycle
    access(12'hB00, 3'd1, 1'b1, 5'd0, 32'h7000_0000, 1'b0);
    chk("R3 write-only returns zero", rsp_rdata, 32'h0);
    access(12'hC00, 3'd2, 1'b0, 5'd0, 32'h0, 1'b0);
    chk("R10 cycle low written exactly", rsp_rdata, 32'h7000_0000);
    access(12'hC80, 3'd2, 1'b0, 5'd0, 32'h0, 1'b0);
    chk("R10 cycle high untouched", rsp_rdata, 32'h0);

    // R9: carry from low half into high half
    access(12'hB80, 3'd1, 1'b1, 5'd0, 32'h5, 1'b0);
    access(12'hB00, 3'd1, 1'b0, 5'd0, 32'hFFFF_FFFF, 1'b0);
    access(12'hC00, 3'd2, 1'b0, 5'd0, 32'h0, 1'b0);
    chk("R10 cycle low preset", rsp_rdata, 32'hFFFF_FFFF);
    access(12'hC80, 3'd2, 1'b0, 5'd0, 32'h0, 1'b0);
    chk("R9 carry into high half", rsp_rdata, 32'h6);

    // R9: retire strobes
    access(12'hC02, 3'd2, 1'b0, 5'd0, 32'h0, 1'b0);
    v1 = rsp_rdata;
    repeat (3) idle(1'b1);
    access(12'hC02, 3'd2, 1'b0, 5'd0, 32'h0, 1'b0);
    chk("R9 three retires", rsp_rdata - v1, 32'd3);

    // R10: write with retire high in the same cycle
    access(12'hB02, 3'd1, 1'b1, 5'd0, 32'h100, 1'b1);
    access(12'hC02, 3'd2, 1'b0, 5'd0, 32'h0, 1'b0);
    chk("R10 instret write beats retire", rsp_rdata, 32'h100);
    access(12'hC82, 3'd2, 1'b0, 5'd0, 32'h0, 1'b0);
    chk("R10 instret high kept", rsp_rdata, 32'h9);

    // R5: user mode
    set_priv(2'd0);
    access(12'h301, 3'd2, 1'b0, 5'd0, 32'h0, 1'b0);
    chk("R5 user blocked from machine", {31'b0, rsp_illegal}, 32'h1);
    chk("R7 illegal data zero", rsp_rdata, 32'h0);
    access(12'hC01, 3'd2, 1'b0, 5'd0, 32'h0, 1'b0);
    chk("R5 user reads time", rsp_rdata, 32'h9ABC_DEF0);
    access(12'hB02, 3'd1, 1'b1, 5'd0, 32'hDEAD, 1'b0);
    chk("R5 user write to alias", {31'b0, rsp_illegal}, 32'h1);
    access(12'hC02, 3'd2, 1'b0, 5'd0, 32'h0, 1'b0);
    chk("R7 illegal write left counter", rsp_rdata, 32'h100);

    // R5: supervisor mode
    set_priv(2'd1);
    access(12'hF14, 3'd2, 1'b0, 5'd0, 32'h0, 1'b0);
    chk("R5 supervisor blocked from hart id", {31'b0, rsp_illegal}, 32'h1);
    access(12'hC82, 3'd2, 1'b0, 5'd0, 32'h0, 1'b0);
    chk("R5 supervisor reads user counter", rsp_rdata, 32'h9);

    set_priv(2'd3);
    access(12'h301, 3'd2, 1'b0, 5'd0, 32'h0, 1'b0);
    chk("R11 machine again reads descriptor", rsp_rdata, ISA);
    chk("R12 machine again legal", {31'b0, rsp_illegal}, 32'h0);

    idle(1'b0);
    finish_run();
  end

endmodule